// File: doc/BRIEF.md
# DRAM Access Sequencer with Refresh and Parity

This block sits between a memory request source and an array of 16K×1 dynamic RAM devices organised as 9-bit bytes: eight data bits and one parity bit. A request is launched by a one-cycle start pulse. It names either a normal access, which is a read or a write at a 14-bit byte address, or a refresh cycle. The block then steps through a five-stage timing chain, one clock per stage. During this chain it drives the 7-bit multiplexed address bus, the row strobe, the column strobe and the write enable.

The 14-bit address is split into two halves. The low half selects the row and goes out first, with the row strobe. The high half selects the column and goes out after the multiplexer switches. On a refresh cycle, a free-running 7-bit refresh counter replaces both halves. The row strobe then pulses with no column phase, and the counter advances when the cycle ends.

On a write, the block appends a parity bit that makes the nine stored bits odd. On a read, it captures the nine returned bits at the end of the data stage. If parity checking is armed and those nine bits hold an even number of ones, it raises an error flag.

Top module: `dram_access_ctrl`

## Requirements
- R1: After reset the block is idle: `busy`, `ras`, `cas` and `wr_en` are low, `par_err` is low, and the refresh counter is 0, so the next refresh cycle presents row 0.
- R2: A high `start` sampled while idle begins a five-cycle sequence. In the cycle after that edge, `busy` rises and `ras` rises. `ras` stays high through stages 1 to 4 and is low in stage 5, the precharge stage. `busy` falls in the cycle after stage 5.
- R3: On an access cycle, `ma` carries `addr[6:0]` in stage 1 and `addr[13:7]` in stages 2 to 4. The address is the one sampled with `start`.
- R4: On an access cycle, `cas` is high in stages 3 and 4 only. On a write (`we` high at start), `wr_en` is high in stage 4 only. `cas` is never high while `ras` is low.
- R5: `mem_d[7:0]` holds the write data sampled with `start`, and `mem_d[8]` is the parity bit. The nine bits of `mem_d` always hold an odd number of ones.
- R6: On a read cycle, `rdata` takes `mem_rdq[7:0]` as sampled at the end of stage 4 and shows it from stage 5 onwards.
- R7: At the end of stage 4 of a read cycle, `par_err` becomes 1 if `chk_arm` is high and `mem_rdq[8:0]` holds an even number of ones; otherwise it becomes 0. Write and refresh cycles leave `par_err` unchanged.
- R8: A refresh cycle (`refresh` high at start) drives the refresh counter on `ma` in stages 1 to 4, raises `ras` as in R2, and never raises `cas` or `wr_en`.
- R9: The refresh counter increases by one at the end of each refresh cycle and wraps from 127 to 0.
- R10: A high `start` while `busy` is high is ignored. The running sequence keeps its timing and address, and no new sequence follows it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Launches a cycle when idle |
| refresh | input | 1 | Cycle type at start: 1 = refresh, 0 = access |
| we | input | 1 | Access type at start: 1 = write, 0 = read |
| addr | input | 14 | Byte address; [6:0] row, [13:7] column |
| wdata | input | 8 | Write data |
| chk_arm | input | 1 | Parity checking armed |
| mem_rdq | input | 9 | Nine bits read from the array, bit 8 parity |
| ma | output | 7 | Multiplexed array address |
| ras | output | 1 | Row strobe, active high |
| cas | output | 1 | Column strobe, active high |
| wr_en | output | 1 | Array write enable, active high |
| mem_d | output | 9 | Nine bits to store, bit 8 parity |
| rdata | output | 8 | Captured read data |
| par_err | output | 1 | Parity error flag |
| busy | output | 1 | Sequence in progress |

## Verification
Two pairs of events can meet in one cycle. The first is a new `start` arriving while a sequence is still running. The bench raises `start` in the row stage of a running cycle. It then judges the result by `ma` and the strobes: they must keep the first cycle's address and timing, and `busy` must be low one cycle after precharge. The second is the end of a read, when the data capture and the parity judgement happen on the same edge. Vectors mix armed and disarmed checking with even and odd stored patterns. Writes are placed between failing and passing reads to show that the flag holds its value across them.

// File: rtl/dram_pkg.sv
package dram_pkg;
  typedef enum logic [2:0] {
    ST_IDLE = 3'd0,
    ST_ROW  = 3'd1,
    ST_MUX  = 3'd2,
    ST_COL  = 3'd3,
    ST_DATA = 3'd4,
    ST_PRE  = 3'd5
  } stage_e;
endpackage

// File: rtl/dram_stage_seq.sv
module dram_stage_seq
  import dram_pkg::*;
(
  input  logic   clk,
  input  logic   rst_n,
  input  logic   start,
  output stage_e stage,
  output logic   launch,
  output logic   finish
);
  stage_e stage_q;

  assign launch = (stage_q == ST_IDLE) && start;
  assign finish = (stage_q == ST_PRE);
  assign stage  = stage_q;

  always_ff @(posedge clk) begin
    if (!rst_n) stage_q <= ST_IDLE;
    else begin
      unique case (stage_q)
        ST_IDLE: if (start) stage_q <= ST_ROW;
        ST_ROW:  stage_q <= ST_MUX;
        ST_MUX:  stage_q <= ST_COL;
        ST_COL:  stage_q <= ST_DATA;
        ST_DATA: stage_q <= ST_PRE;
        default: stage_q <= ST_IDLE;
      endcase
    end
  end

  // R2: the chain advances one stage per clock
  a_r2_row_to_mux: assert property (@(posedge clk) disable iff (!rst_n)
    stage_q == ST_ROW |=> stage_q == ST_MUX);
  a_r2_pre_to_idle: assert property (@(posedge clk) disable iff (!rst_n)
    stage_q == ST_PRE |=> stage_q == ST_IDLE);
  // R10: no restart from the middle of a sequence
  a_r10_no_restart: assert property (@(posedge clk) disable iff (!rst_n)
    (stage_q != ST_IDLE) |=> stage_q != ST_ROW);
endmodule

// File: rtl/dram_addr_sel.sv
module dram_addr_sel
  import dram_pkg::*;
#(
  parameter int ROW_W = 7
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               launch,
  input  logic               finish,
  input  logic               refresh_in,
  input  logic [2*ROW_W-1:0] addr_in,
  input  stage_e             stage,
  output logic [ROW_W-1:0]   ma,
  output logic               cyc_refresh,
  output logic               refresh_done
);
  localparam int ADDR_W = 2 * ROW_W;

  logic [ADDR_W-1:0] addr_q;
  logic [ROW_W-1:0]  rcnt_q;
  logic              refresh_q;

  function automatic logic [ROW_W-1:0] next_row(input logic [ROW_W-1:0] r);
    return r + 1'b1;
  endfunction

  assign cyc_refresh  = refresh_q;
  assign refresh_done = finish && refresh_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      addr_q    <= '0;
      refresh_q <= 1'b0;
      rcnt_q    <= '0;
    end else begin
      if (launch) begin
        addr_q    <= addr_in;
        refresh_q <= refresh_in;
      end
      if (refresh_done) rcnt_q <= next_row(rcnt_q);
    end
  end

  always_comb begin
    if (refresh_q)              ma = rcnt_q;
    else if (stage == ST_IDLE || stage == ST_ROW) ma = addr_q[ROW_W-1:0];
    else                        ma = addr_q[ADDR_W-1:ROW_W];
  end

  // R9: the refresh row moves by exactly one after each refresh cycle
  a_r9_count_step: assert property (@(posedge clk) disable iff (!rst_n)
    refresh_done |=> rcnt_q == next_row($past(rcnt_q)));
  // R9: the refresh row is unchanged by any other cycle
  a_r9_count_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !refresh_done |=> $stable(rcnt_q));
  // R3: the address is held through the whole sequence
  a_r3_addr_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !launch |=> $stable(addr_q));
endmodule

// File: rtl/dram_parity.sv
module dram_parity #(
  parameter int DATA_W = 8
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            launch,
  input  logic [DATA_W-1:0] wdata_in,
  input  logic            rd_cap,
  input  logic            chk_arm,
  input  logic [DATA_W:0] rdq,
  output logic [DATA_W:0] mem_d,
  output logic [DATA_W-1:0] rdata,
  output logic            par_err
);
  logic [DATA_W-1:0] wdata_q;

  function automatic logic fill_bit(input logic [DATA_W-1:0] d);
    return ~(^d);
  endfunction

  function automatic logic word_is_even(input logic [DATA_W:0] w);
    return ~(^w);
  endfunction

  assign mem_d = {fill_bit(wdata_q), wdata_q};

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      wdata_q <= '0;
      rdata   <= '0;
      par_err <= 1'b0;
    end else begin
      if (launch) wdata_q <= wdata_in;
      if (rd_cap) begin
        rdata   <= rdq[DATA_W-1:0];
        par_err <= chk_arm && word_is_even(rdq);
      end
    end
  end

  // R5: the stored word always carries odd parity
  a_r5_odd_store: assert property (@(posedge clk) disable iff (!rst_n)
    $countones(mem_d) % 2 == 1);
  // R7: an even word read with checking armed raises the flag
  a_r7_flag_set: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_cap && chk_arm && ($countones(rdq) % 2 == 0)) |=> par_err);
  // R7: the flag only moves at a read capture
  a_r7_flag_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_cap |=> $stable(par_err));
endmodule

// File: rtl/dram_access_ctrl.sv
module dram_access_ctrl
  import dram_pkg::*;
#(
  parameter int ROW_W  = 7,
  parameter int DATA_W = 8
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 start,
  input  logic                 refresh,
  input  logic                 we,
  input  logic [2*ROW_W-1:0]   addr,
  input  logic [DATA_W-1:0]    wdata,
  input  logic                 chk_arm,
  input  logic [DATA_W:0]      mem_rdq,
  output logic [ROW_W-1:0]     ma,
  output logic                 ras,
  output logic                 cas,
  output logic                 wr_en,
  output logic [DATA_W:0]      mem_d,
  output logic [DATA_W-1:0]    rdata,
  output logic                 par_err,
  output logic                 busy
);
  stage_e stage;
  logic   launch, finish;
  logic   cyc_refresh, refresh_done;
  logic   we_q;
  logic   rd_cap;

  dram_stage_seq u_seq (
    .clk    (clk),
    .rst_n  (rst_n),
    .start  (start),
    .stage  (stage),
    .launch (launch),
    .finish (finish)
  );

  dram_addr_sel #(.ROW_W(ROW_W)) u_addr (
    .clk          (clk),
    .rst_n        (rst_n),
    .launch       (launch),
    .finish       (finish),
    .refresh_in   (refresh),
    .addr_in      (addr),
    .stage        (stage),
    .ma           (ma),
    .cyc_refresh  (cyc_refresh),
    .refresh_done (refresh_done)
  );

  always_ff @(posedge clk) begin
    if (!rst_n)      we_q <= 1'b0;
    else if (launch) we_q <= we;
  end

  assign busy   = (stage != ST_IDLE);
  assign ras    = (stage == ST_ROW) || (stage == ST_MUX) ||
                  (stage == ST_COL) || (stage == ST_DATA);
  assign cas    = !cyc_refresh && ((stage == ST_COL) || (stage == ST_DATA));
  assign wr_en  = !cyc_refresh && we_q && (stage == ST_DATA);
  assign rd_cap = !cyc_refresh && !we_q && (stage == ST_DATA);

  dram_parity #(.DATA_W(DATA_W)) u_par (
    .clk      (clk),
    .rst_n    (rst_n),
    .launch   (launch),
    .wdata_in (wdata),
    .rd_cap   (rd_cap),
    .chk_arm  (chk_arm),
    .rdq      (mem_rdq),
    .mem_d    (mem_d),
    .rdata    (rdata),
    .par_err  (par_err)
  );

  // R4: column strobe only inside a row strobe
  a_r4_cas_in_ras: assert property (@(posedge clk) disable iff (!rst_n)
    cas |-> ras);
  // R4: write enable only with the column strobe
  a_r4_we_in_cas: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |-> cas);
  // R8: a refresh cycle has no column phase and no write
  a_r8_refresh_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && cyc_refresh) |-> (!cas && !wr_en));
  // R2: a start while idle raises the row strobe next cycle
  a_r2_start_ras: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && start) |=> ras);
endmodule

// File: tb/sim_dram_access_ctrl.sv
module sim_dram_access_ctrl;
  localparam int CLK_PERIOD = 10;

  typedef struct packed {
    logic        we;
    logic [13:0] addr;
    logic [7:0]  wd;
    logic [8:0]  rdq;
    logic        arm;
  } vec_t;

  localparam int NV = 7;
  localparam vec_t VECS [NV] = '{
    '{1'b1, 14'h3A5C, 8'hA5, 9'h000, 1'b1},
    '{1'b0, 14'h1234, 8'h00, 9'h0FF, 1'b1},
    '{1'b1, 14'h0001, 8'h01, 9'h000, 1'b1},
    '{1'b0, 14'h3FFF, 8'h00, 9'h1FF, 1'b1},
    '{1'b0, 14'h2080, 8'h00, 9'h0FF, 1'b0},
    '{1'b0, 14'h0F0F, 8'h00, 9'h003, 1'b1},
    '{1'b1, 14'h1555, 8'hFE, 9'h000, 1'b0}
  };

  logic clk = 1'b0, rst_n = 1'b0;
  logic start = 1'b0, refresh = 1'b0, we = 1'b0, chk_arm = 1'b0;
  logic [13:0] addr = '0;
  logic [7:0]  wdata = '0;
  logic [8:0]  mem_rdq = '0;
  logic [6:0]  ma;
  logic ras, cas, wr_en, par_err, busy;
  logic [8:0]  mem_d;
  logic [7:0]  rdata;

  int n_chk = 0, n_bad = 0;
  bit done = 1'b0;
  logic exp_err = 1'b0;
  logic [6:0] exp_row = '0;

  always #(CLK_PERIOD/2) clk = ~clk;

  dram_access_ctrl u0 (
    .clk(clk), .rst_n(rst_n), .start(start), .refresh(refresh), .we(we),
    .addr(addr), .wdata(wdata), .chk_arm(chk_arm), .mem_rdq(mem_rdq),
    .ma(ma), .ras(ras), .cas(cas), .wr_en(wr_en), .mem_d(mem_d),
    .rdata(rdata), .par_err(par_err), .busy(busy)
  );

  function automatic int ones9(input logic [8:0] v);
    int c = 0;
    for (int i = 0; i < 9; i++) if (v[i]) c++;
    return c;
  endfunction

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic strobes(input string tag, input logic r, input logic c, input logic w);
    check(ras === r, {tag, " ras"}, ras, r);
    check(cas === c, {tag, " cas"}, cas, c);
    check(wr_en === w, {tag, " wr_en"}, wr_en, w);
  endtask

  // one access cycle; poke raises start again during stage 1 (R10)
  task automatic access(input vec_t v, input bit poke);
    logic [6:0] row = v.addr[6:0];
    logic [6:0] col = v.addr[13:7];
    bit rd = !v.we;
    @(negedge clk);
    refresh = 1'b0; we = v.we; addr = v.addr; wdata = v.wd;
    mem_rdq = v.rdq; chk_arm = v.arm; start = 1'b1;
    @(negedge clk); start = 1'b0;
    check(busy === 1'b1, "R2 busy stage1", busy, 1);
    strobes("R2 R4 stage1", 1'b1, 1'b0, 1'b0);
    check(ma === row, "R3 row on ma", ma, row);
    if (poke) begin start = 1'b1; addr = ~v.addr; end
    @(negedge clk); start = 1'b0;
    strobes("R4 stage2", 1'b1, 1'b0, 1'b0);
    check(ma === col, "R3 col stage2", ma, col);
    @(negedge clk);
    strobes("R4 stage3", 1'b1, 1'b1, 1'b0);
    check(ma === col, "R3 col stage3", ma, col);
    @(negedge clk);
    strobes("R4 stage4", 1'b1, 1'b1, v.we);
    check(ma === col, "R3 col stage4", ma, col);
    if (v.we) begin
      check(mem_d[7:0] === v.wd, "R5 data bits", mem_d[7:0], v.wd);
      check(ones9(mem_d) % 2 == 1, "R5 odd parity", mem_d, {~^v.wd, v.wd});
    end
    @(negedge clk);
    strobes("R2 stage5", 1'b0, 1'b0, 1'b0);
    check(busy === 1'b1, "R2 busy stage5", busy, 1);
    if (rd) begin
      exp_err = v.arm && (ones9(v.rdq) % 2 == 0);
      check(rdata === v.rdq[7:0], "R6 rdata", rdata, v.rdq[7:0]);
    end
    check(par_err === exp_err, "R7 par_err", par_err, exp_err);
    @(negedge clk);
    check(busy === 1'b0, poke ? "R10 idle after poke" : "R2 idle", busy, 0);
    check(ras === 1'b0, "R2 ras idle", ras, 0);
  endtask

  task automatic refresh_cycle(input bit full);
    @(negedge clk);
    refresh = 1'b1; we = 1'b1; addr = 14'h2AAA; start = 1'b1;
    @(negedge clk); start = 1'b0; refresh = 1'b0;
    check(ma === exp_row, "R9 refresh row", ma, exp_row);
    check(ras === 1'b1 && cas === 1'b0, "R8 stage1 ras only", {ras, cas}, 2'b10);
    for (int s = 2; s <= 4; s++) begin
      @(negedge clk);
      if (full) begin
        check(ma === exp_row, "R8 refresh ma held", ma, exp_row);
        strobes("R8 refresh", 1'b1, 1'b0, 1'b0);
      end
    end
    @(negedge clk);
    check(ras === 1'b0, "R8 refresh precharge", ras, 0);
    check(par_err === exp_err, "R7 flag kept by refresh", par_err, exp_err);
    @(negedge clk);
    exp_row = exp_row + 7'd1;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check(busy === 1'b0, "R1 busy", busy, 0);
    strobes("R1 reset", 1'b0, 1'b0, 1'b0);
    check(par_err === 1'b0, "R1 par_err", par_err, 0);
    refresh_cycle(1'b1);  // R1: first refresh row is 0

    for (int i = 0; i < NV; i++) access(VECS[i], 1'b0);

    access('{1'b0, 14'h0ABC, 8'h00, 9'h0FE, 1'b1}, 1'b1); // R10
    access('{1'b0, 14'h3210, 8'h00, 9'h101, 1'b1}, 1'b0); // R7 set
    refresh_cycle(1'b1);                                  // R7 kept
    access('{1'b1, 14'h0042, 8'h00, 9'h000, 1'b1}, 1'b0); // R5 zero data

    for (int k = 0; k < 130; k++) refresh_cycle(1'b0);    // R9 wrap
    refresh_cycle(1'b1);
    done = 1'b1;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog actual=hung expected=done");
    end
  end

  initial begin
    wait (done || n_chk < 0);
    fork
      wait (done);
      begin repeat (20000) @(posedge clk); end
    join_any
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule